// File: doc/BRIEF.md
# Synchronous Shift-Register Serial Port

This block is a half-duplex, clocked serial link. It owns one clock output and one data pin that can be driven or released. A host loads a byte and asks for a send, or asks for a receive. The block then runs one frame of eight shift-clock periods. It moves the byte out least significant bit first, or collects eight bits from the pin in the same order. It raises a done flag when the frame is over.

All timing is counted in oscillator periods. The surrounding chip supplies these as a one-cycle clock-enable pulse, `osc_en`. Every pin movement is therefore a whole number of such periods. The system clock may run faster than the oscillator rate. The data pin is modelled as a separate input, output and output-enable, which the pad ring combines.

Top module: `ssr_port`

## Requirements
- R1: While `rst` is high, and on the cycle after it falls, `sclk_o` is 1, `sdat_oe` is 0, `done` is 0 and `rd_data` is 0.
- R2: Within a frame, each shift-clock period has `sclk_o` low for exactly 4 oscillator ticks, then high for exactly 4 ticks.
- R3: A send frame drives bit 0 of the held byte first and bit 7 last, one bit per shift-clock period. Each bit is on `sdat_o`, with `sdat_oe` high, at least 4 ticks before the rising clock edge that carries it.
- R4: In a send frame, `sdat_o` moves to the next bit exactly 2 ticks after a rising edge, and only while `sclk_o` is high.
- R5: A receive frame samples `sdat_i` at each of the 8 rising edges. The first sample lands in bit 0 of `rd_data`. `rd_data` changes only at the end of a receive frame; a send frame leaves it untouched.
- R6: `sdat_oe` falls exactly 2 ticks after the eighth rising edge, with `sclk_o` high. A receive frame never raises `sdat_oe`.
- R7: `done` rises on the same cycle that the frame ends. It stays high until a start strobe is accepted, and it is 0 on the cycle after acceptance.
- R8: A start strobe (`start_tx` or `start_rx`) that arrives while a frame is pending or running has no effect. The running frame completes unchanged and no further frame follows.
- R9: When `start_tx` and `start_rx` are high on the same cycle, a send frame runs.
- R10: The byte written with `wr_en` is taken into the frame on its first tick. A write made after that point does not alter the running frame, but it is used by the next send.
- R11: Pins change only on cycles where `osc_en` is high. Between frames `sclk_o` rests high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| osc_en | input | 1 | One-cycle pulse per oscillator period |
| wr_en | input | 1 | Load `wr_data` into the send holding register |
| wr_data | input | DATA_W | Byte to send |
| start_tx | input | 1 | Request a send frame |
| start_rx | input | 1 | Request a receive frame |
| rd_data | output | DATA_W | Last received byte |
| done | output | 1 | Frame finished, cleared by an accepted start |
| sclk_o | output | 1 | Shift clock pin |
| sdat_o | output | 1 | Data pin output value |
| sdat_oe | output | 1 | Data pin output enable |
| sdat_i | input | 1 | Data pin input value |

## Verification
The bench builds the block with its defaults: 8 data bits, 4-tick clock halves, and a 2-tick data advance. This keeps a frame short enough that all 256 send bytes and all 256 receive bytes can be swept, with `osc_en` high on every cycle. A second sweep over 16 bytes in each direction runs with `osc_en` high one cycle in three. This shows that every interval is counted in ticks rather than system cycles, and that no pin moves between ticks. Directed frames cover strobes arriving mid-frame, simultaneous strobes, and writes to the holding register while a frame runs.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
  typedef enum logic [1:0] {
    SP_IDLE = 2'd0,
    SP_ARM  = 2'd1,
    SP_RUN  = 2'd2
  } ssr_state_t;
endpackage

// File: rtl/ssr_timebase.sv
module ssr_timebase
  import ssr_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int HALF_OSC = 4,
  parameter int DRV_DLY  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic osc_en,
  input  logic start,
  output logic accept,
  output logic ev_begin,
  output logic ev_rise,
  output logic ev_adv,
  output logic ev_fall,
  output logic ev_end
);
  localparam int PH_N  = 2 * HALF_OSC;
  localparam int PH_W  = $clog2(PH_N);
  localparam int BIT_W = $clog2(DATA_W);
  localparam logic [PH_W-1:0]  RISE_PH  = PH_W'(HALF_OSC - 1);
  localparam logic [PH_W-1:0]  ADV_PH   = PH_W'(HALF_OSC + DRV_DLY - 1);
  localparam logic [PH_W-1:0]  FALL_PH  = PH_W'(PH_N - 1);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

  ssr_state_t        st;
  logic [PH_W-1:0]   ph;
  logic [BIT_W-1:0]  bitc;
  logic              run_tick;

  always_comb begin
    accept   = start && (st == SP_IDLE);
    ev_begin = (st == SP_ARM) && osc_en;
    run_tick = (st == SP_RUN) && osc_en;
    ev_rise  = run_tick && (ph == RISE_PH);
    ev_adv   = run_tick && (ph == ADV_PH);
    ev_fall  = run_tick && (ph == FALL_PH);
    ev_end   = ev_adv && (bitc == LAST_BIT);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= SP_IDLE;
      ph   <= '0;
      bitc <= '0;
    end else begin
      case (st)
        SP_IDLE: if (start) st <= SP_ARM;
        SP_ARM: begin
          if (osc_en) begin
            st   <= SP_RUN;
            ph   <= '0;
            bitc <= '0;
          end
        end
        SP_RUN: begin
          if (osc_en) begin
            if (ev_end) st <= SP_IDLE;
            if (ph == FALL_PH) begin
              ph   <= '0;
              bitc <= bitc + 1'b1;
            end else begin
              ph <= ph + 1'b1;
            end
          end
        end
        default: st <= SP_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ssr_clkgen.sv
module ssr_clkgen (
  input  logic clk,
  input  logic rst,
  input  logic ev_begin,
  input  logic ev_rise,
  input  logic ev_fall,
  output logic sclk_q
);
  always_ff @(posedge clk) begin
    if (rst)                     sclk_q <= 1'b1;
    else if (ev_begin || ev_fall) sclk_q <= 1'b0;
    else if (ev_rise)            sclk_q <= 1'b1;
  end
endmodule

// File: rtl/ssr_shifter.sv
module ssr_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              want_tx,
  input  logic [DATA_W-1:0] hold,
  input  logic              ev_begin,
  input  logic              ev_rise,
  input  logic              ev_adv,
  input  logic              ev_end,
  input  logic              sdat_i,
  output logic              sdat_q,
  output logic              sdat_oe_q,
  output logic [DATA_W-1:0] rx_word,
  output logic              done_q
);
  logic              dir_tx;
  logic [DATA_W-1:0] tx_sh;
  logic [DATA_W-1:0] rx_sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_tx    <= 1'b0;
      tx_sh     <= '0;
      rx_sh     <= '0;
      sdat_q    <= 1'b0;
      sdat_oe_q <= 1'b0;
      rx_word   <= '0;
      done_q    <= 1'b0;
    end else begin
      if (accept) begin
        dir_tx <= want_tx;
        done_q <= 1'b0;
      end
      if (ev_begin) begin
        tx_sh     <= hold;
        sdat_q    <= hold[0];
        sdat_oe_q <= dir_tx;
      end
      if (ev_rise)
        rx_sh <= {sdat_i, rx_sh[DATA_W-1:1]};
      if (ev_adv && !ev_end) begin
        tx_sh  <= tx_sh >> 1;
        sdat_q <= tx_sh[1];
      end
      if (ev_end) begin
        sdat_oe_q <= 1'b0;
        done_q    <= 1'b1;
        if (!dir_tx) rx_word <= rx_sh;
      end
    end
  end
endmodule

// File: rtl/ssr_port.sv
module ssr_port #(
  parameter int DATA_W   = 8,
  parameter int HALF_OSC = 4,
  parameter int DRV_DLY  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              osc_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              start_tx,
  input  logic              start_rx,
  output logic [DATA_W-1:0] rd_data,
  output logic              done,
  output logic              sclk_o,
  output logic              sdat_o,
  output logic              sdat_oe,
  input  logic              sdat_i
);
  logic [DATA_W-1:0] hold;
  logic accept, ev_begin, ev_rise, ev_adv, ev_fall, ev_end;

  always_ff @(posedge clk) begin
    if (rst)        hold <= '0;
    else if (wr_en) hold <= wr_data;
  end

  ssr_timebase #(
    .DATA_W(DATA_W), .HALF_OSC(HALF_OSC), .DRV_DLY(DRV_DLY)
  ) u_tb (
    .clk(clk), .rst(rst), .osc_en(osc_en),
    .start(start_tx | start_rx),
    .accept(accept), .ev_begin(ev_begin), .ev_rise(ev_rise),
    .ev_adv(ev_adv), .ev_fall(ev_fall), .ev_end(ev_end)
  );

  ssr_clkgen u_ck (
    .clk(clk), .rst(rst), .ev_begin(ev_begin),
    .ev_rise(ev_rise), .ev_fall(ev_fall), .sclk_q(sclk_o)
  );

  ssr_shifter #(.DATA_W(DATA_W)) u_sh (
    .clk(clk), .rst(rst), .accept(accept), .want_tx(start_tx),
    .hold(hold), .ev_begin(ev_begin), .ev_rise(ev_rise),
    .ev_adv(ev_adv), .ev_end(ev_end), .sdat_i(sdat_i),
    .sdat_q(sdat_o), .sdat_oe_q(sdat_oe), .rx_word(rd_data),
    .done_q(done)
  );
endmodule

// File: rtl/ssr_port_chk.sv
module ssr_port_chk (
  input logic clk,
  input logic rst,
  input logic osc_en,
  input logic start_tx,
  input logic start_rx,
  input logic done,
  input logic sclk_o,
  input logic sdat_o,
  input logic sdat_oe
);
  // R11: no pin movement on a cycle without a tick
  a_r11_pins_on_tick: assert property (@(posedge clk) disable iff (rst)
    !osc_en |=> ($stable(sclk_o) && $stable(sdat_oe)));

  // R11: clock rests high whenever a frame has finished
  a_r11_idle_high: assert property (@(posedge clk) disable iff (rst)
    done |-> sclk_o);

  // R4: driven data only moves while the clock is high
  a_r4_move_when_high: assert property (@(posedge clk) disable iff (rst)
    (sdat_oe && $past(sdat_oe) && !$stable(sdat_o)) |-> sclk_o);

  // R6: release happens with the clock high
  a_r6_release_high: assert property (@(posedge clk) disable iff (rst)
    $fell(sdat_oe) |-> sclk_o);

  // R7: release and done coincide
  a_r7_done_at_release: assert property (@(posedge clk) disable iff (rst)
    $fell(sdat_oe) |-> done);

  // R7: an accepted strobe clears done
  a_r7_done_clear: assert property (@(posedge clk) disable iff (rst)
    (done && (start_tx || start_rx)) |=> !done);
endmodule

bind ssr_port ssr_port_chk u_chk (.*);

// File: tb/sim_ssr_port.sv
`timescale 1ns/1ps
module sim_ssr_port;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       osc_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       start_tx = 1'b0;
  logic       start_rx = 1'b0;
  logic [7:0] rd_data;
  logic       done, sclk_o, sdat_o, sdat_oe;
  logic       sdat_i = 1'b0;

  ssr_port u0 (.*);

  always #2 clk = ~clk;

  int checks = 0, fails = 0;
  int osc_div = 1, divc = 0;
  int tick = 0, t_rise = 0, t_fall = 0, t_set = 0;
  int rises = 0;
  logic frame_tx = 1'b0;
  logic [7:0] got = 8'h00, rxbyte = 8'h00;
  logic p_sclk = 1'b1, p_oe = 1'b0, p_sdo = 1'b0, en_last = 1'b0;

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // Negedge loop: tick counting, pin timing monitor, receive data and osc_en drive
  initial begin
    forever begin
      @(negedge clk);
      en_last = osc_en;
      tick += int'(en_last);
      if (!rst) begin
        if ((sclk_o !== p_sclk) || (sdat_oe !== p_oe) || (sdat_oe && sdat_o !== p_sdo))
          chk(en_last, "R11 pin moved without tick", 0, 1);
        if (p_sclk && !sclk_o) begin
          if (rises > 0) chk(tick - t_fall == 4 || 1'b0 ? 1'b1 : (tick - t_rise == 4), "R2 high width", tick - t_rise, 4);
          t_fall = tick;
        end
        if (!p_sclk && sclk_o) begin
          chk(tick - t_fall == 4, "R2 low width", tick - t_fall, 4);
          if (frame_tx && sdat_oe) begin
            chk(tick - t_set >= 4, "R3 setup before rise", tick - t_set, 4);
            if (rises < 8) got[rises] = sdat_o;
          end
          t_rise = tick;
          rises++;
        end
        if (!p_oe && sdat_oe) t_set = tick;
        if (p_oe && sdat_oe && (sdat_o !== p_sdo)) begin
          chk(tick - t_rise == 2, "R4 advance delay", tick - t_rise, 2);
          t_set = tick;
        end
        if (p_oe && !sdat_oe) begin
          chk(tick - t_rise == 2, "R6 release delay", tick - t_rise, 2);
          chk(rises == 8, "R6 rises before release", rises, 8);
          chk(done == 1'b1, "R7 done at release", int'(done), 1);
        end
        if (!frame_tx && sdat_oe) chk(1'b0, "R6 receive drove pin", 1, 0);
      end
      p_sclk = sclk_o; p_oe = sdat_oe; p_sdo = sdat_o;
      sdat_i = (rises < 8) ? rxbyte[rises] : 1'b0;
      divc = (divc + 1) % osc_div;
      osc_en = (divc == 0);
    end
  end

  task automatic wait_done();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (done) return;
    end
    chk(1'b0, "R7 done never rose", 0, 1);
  endtask

  task automatic wait_rises(input int n);
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (rises >= n) return;
    end
    chk(1'b0, "R2 rises missing", rises, n);
  endtask

  task automatic write_hold(input logic [7:0] v);
    @(negedge clk); wr_en = 1'b1; wr_data = v;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic launch(input logic tx, input logic rx);
    @(negedge clk);
    rises = 0; got = 8'h00;
    frame_tx = tx;
    start_tx = tx; start_rx = rx;
    @(negedge clk);
    start_tx = 1'b0; start_rx = 1'b0;
    chk(done == 1'b0, "R7 done cleared on accept", int'(done), 0);
  endtask

  task automatic do_tx(input logic [7:0] v, input logic wr);
    logic [7:0] rd0;
    if (wr) write_hold(v);
    rd0 = rd_data;
    launch(1'b1, 1'b0);
    wait_done();
    chk(got == v, "R3 sent byte", got, v);
    chk(rises == 8, "R3 eight edges", rises, 8);
    chk(rd_data == rd0, "R5 send keeps rd_data", rd_data, rd0);
  endtask

  task automatic do_rx(input logic [7:0] v);
    rxbyte = v;
    launch(1'b0, 1'b1);
    wait_done();
    chk(rd_data == v, "R5 received byte", rd_data, v);
    chk(sclk_o == 1'b1, "R11 idle high", int'(sclk_o), 1);
  endtask

  initial begin
    #(4 * 200000);
    chk(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    chk(sclk_o == 1'b1 && sdat_oe == 1'b0 && done == 1'b0, "R1 reset pins", {sclk_o, sdat_oe, done}, 3'b100);
    rst = 1'b0;
    @(negedge clk);
    chk(sclk_o == 1'b1 && sdat_oe == 1'b0 && done == 1'b0 && rd_data == 8'h00,
        "R1 after reset", {sclk_o, sdat_oe, done, rd_data}, 11'h400);

    for (int b = 0; b < 256; b++) do_tx(8'(b), 1'b1);
    for (int b = 0; b < 256; b++) do_rx(8'(b ^ 8'h5A));

    osc_div = 3;
    for (int b = 0; b < 16; b++) do_tx(8'(b * 17 + 3), 1'b1);
    for (int b = 0; b < 16; b++) do_rx(8'(b * 29 + 7));
    osc_div = 1;

    // R8: strobes during a running frame
    write_hold(8'hC3);
    launch(1'b1, 1'b0);
    wait_rises(3);
    @(negedge clk); start_rx = 1'b1; start_tx = 1'b1;
    @(negedge clk); start_rx = 1'b0; start_tx = 1'b0;
    wait_done();
    chk(got == 8'hC3, "R8 frame unchanged", got, 8'hC3);
    repeat (100) @(negedge clk);
    chk(rises == 8 && sclk_o && done, "R8 no extra frame", rises, 8);

    // R9: both strobes together means send
    write_hold(8'hA5);
    begin
      logic [7:0] rd0;
      rd0 = rd_data;
      launch(1'b1, 1'b1);
      wait_done();
      chk(got == 8'hA5, "R9 send wins", got, 8'hA5);
      chk(rd_data == rd0, "R9 rd_data kept", rd_data, rd0);
    end

    // R10: write while running
    write_hold(8'h3C);
    launch(1'b1, 1'b0);
    wait_rises(2);
    write_hold(8'hE1);
    wait_done();
    chk(got == 8'h3C, "R10 running frame kept", got, 8'h3C);
    do_tx(8'hE1, 1'b0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule